// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block is the exception control unit of a small 32-bit core. The pipeline hands it a synchronous exception request with a cause code, the PC of the faulting instruction and an optional faulting virtual address. The block then updates its exception state registers and chooses a handler entry point. It redirects the fetch PC there, and all of these updates land on a single clock edge.

The decode stage also drives strobes for four other operations: return from exception, return from double exception, set interrupt level, and special-register read, write or exchange. The block runs the privileged ones only when the current ring is 0. In any other ring, such an operation is turned into a privilege exception. The block also reports the current interrupt level, which it derives from the processor status word.

A double exception is an exception taken while the exception-mode bit is already set. Its return PC goes into a dedicated register, and it enters through a vector of its own.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `fetch_pc` is 0x5FFF8000 and `ps` is 0x0000001F. `epc1`, `depc`, `exccause`, `excvaddr` and `rsil_old` are all 0, and `redirect_vld` is low.
- R2: Consider an exception taken while PS bit 4 (exception mode) is clear. `epc1` receives the faulting PC. `fetch_pc` becomes 0x5FFF863C when PS bit 5 (user mode) is set, and 0x5FFF861C when it is clear.
- R3: Consider an exception taken while PS bit 4 is set. The faulting PC goes to `depc` (or to `epc1` when HAS_DEPC is 0), and `epc1` keeps its value. `fetch_pc` becomes 0x5FFF865C.
- R4: Every exception writes its cause code, zero-extended, to `exccause`. It sets PS bit 4 and leaves the other PS bits unchanged. `excvaddr` takes the faulting address only when `exc_vaddr_vld` is high; otherwise it holds its value.
- R5: The PC redirect and all register updates of a request appear together one clock after the request. `redirect_vld` is high for exactly that cycle, and it stays low after a cycle with no request or operation strobe.
- R6: Return from exception clears PS bit 4 and redirects `fetch_pc` to `epc1`.
- R7: Return from double exception redirects `fetch_pc` to `depc` (to `epc1` when HAS_DEPC is 0) and leaves PS unchanged.
- R8: Set interrupt level copies the old PS into `rsil_old` and replaces PS bits 3:0 with `rsil_lvl`.
- R9: The ring is PS bits 7:6 (taken as 0 when HAS_MMU is 0). When the ring is not 0, the following operations take a cause-8 exception at `op_pc` instead of executing: either return, set interrupt level, and any special-register access numbered 64 or above.
- R10: A special-register access numbered below 64 never faults, whatever the ring. A write to a number the block does not hold changes no output.
- R11: `cur_level` equals PS bits 3:0. When PS bit 4 is set and EXCM_LEVEL is higher than that field, `cur_level` equals EXCM_LEVEL instead.
- R12: When `exc_req` and an operation strobe arrive in the same cycle, the exception is taken and the operation is dropped.
- R13: Special-register numbers are 177 for `epc1`, 192 for `depc`, 230 for `ps`, 232 for `exccause` and 238 for `excvaddr`. `sr_rdata` shows the addressed register's current value (0 for any other number), and a permitted write replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 6 | Cause code of the request |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_vaddr_vld | input | 1 | Faulting address present |
| exc_vaddr | input | 32 | Faulting virtual address |
| op_pc | input | 32 | PC of the instruction driving an operation strobe |
| op_rfe | input | 1 | Return from exception |
| op_rfde | input | 1 | Return from double exception |
| op_rsil | input | 1 | Set interrupt level |
| rsil_lvl | input | 4 | New interrupt level |
| sr_rd | input | 1 | Special-register read |
| sr_wr | input | 1 | Special-register write (with sr_rd: exchange) |
| sr_num | input | 8 | Special-register number |
| sr_wdata | input | 32 | Write data |
| fetch_pc | output | 32 | Redirected fetch PC |
| redirect_vld | output | 1 | fetch_pc changed this cycle |
| ps | output | 32 | Processor status word |
| epc1 | output | 32 | Exception return PC |
| depc | output | 32 | Double-exception return PC |
| exccause | output | 32 | Last cause code |
| excvaddr | output | 32 | Last faulting address |
| rsil_old | output | 32 | PS value before the last set-interrupt-level |
| cur_level | output | 4 | Current interrupt level |
| sr_rdata | output | 32 | Special-register read data |

## Verification
Suppose the exception-mode bit in PS holds a wrong value. The next exception would then enter through the wrong one of the three vectors and save its PC in the wrong register. That shows on `fetch_pc` and `epc1`/`depc` one clock after the request, and `cur_level` shows it at once. Suppose instead that the ring field is decoded wrongly. A return executed in ring 1 would then redirect to `epc1` instead of trapping with cause 8, which is visible on the very next edge. The scoreboard compares every state output after each operation, so any corrupted register is reported within one cycle of the operation that exposes it.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN = 32;

    localparam logic [XLEN-1:0] VEC_RESET  = 32'h5FFF_8000;
    localparam logic [XLEN-1:0] VEC_KERNEL = 32'h5FFF_861C;
    localparam logic [XLEN-1:0] VEC_USER   = 32'h5FFF_863C;
    localparam logic [XLEN-1:0] VEC_DOUBLE = 32'h5FFF_865C;

    localparam logic [XLEN-1:0] PS_RESET = 32'h0000_001F;
    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;
    localparam int PS_RING_LSB = 6;

    localparam logic [7:0] SR_EPC1  = 8'd177;
    localparam logic [7:0] SR_DEPC  = 8'd192;
    localparam logic [7:0] SR_PS    = 8'd230;
    localparam logic [7:0] SR_CAUSE = 8'd232;
    localparam logic [7:0] SR_VADDR = 8'd238;
    localparam logic [7:0] SR_PRIV_BASE = 8'd64;

    localparam int CAUSE_PRIVILEGED = 8;

    typedef struct packed {
        logic [XLEN-1:0] fetch_pc;
        logic [XLEN-1:0] epc1;
        logic [XLEN-1:0] depc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] vaddr;
        logic [XLEN-1:0] ps;
        logic [XLEN-1:0] old_ps;
        logic            redirect;
    } ctl_state_t;
endpackage

// File: rtl/exc_priv_check.sv
module exc_priv_check #(
    parameter int HAS_MMU = 1,
    parameter int SRN_W   = 8
) (
    input  logic [1:0]       ring_bits,
    input  logic             op_rfe,
    input  logic             op_rfde,
    input  logic             op_rsil,
    input  logic             sr_rd,
    input  logic             sr_wr,
    input  logic [SRN_W-1:0] sr_num,
    output logic             fault
);
    import exc_pkg::*;

    logic [1:0] ring;
    logic       priv_op;

    generate
        if (HAS_MMU != 0) begin : g_ring
            assign ring = ring_bits;
        end else begin : g_flat
            assign ring = 2'b00;
        end
    endgenerate

    // Special registers at or above the base number need ring 0.
    assign priv_op = op_rfe | op_rfde | op_rsil
                   | ((sr_rd | sr_wr) & (sr_num >= SRN_W'(SR_PRIV_BASE)));
    assign fault   = priv_op & (ring != 2'b00);
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel (
    input  logic        excm,
    input  logic        um,
    output logic        dbl,
    output logic [31:0] vector
);
    import exc_pkg::*;

    assign dbl = excm;

    always_comb begin
        if (excm)    vector = VEC_DOUBLE;
        else if (um) vector = VEC_USER;
        else         vector = VEC_KERNEL;
    end
endmodule

// File: rtl/exc_level_calc.sv
module exc_level_calc #(
    parameter int LVL_W      = 4,
    parameter int EXCM_LEVEL = 3
) (
    input  logic [LVL_W-1:0] intlevel,
    input  logic             excm,
    output logic [LVL_W-1:0] cur_level
);
    localparam logic [LVL_W-1:0] EXCM_LV = LVL_W'(EXCM_LEVEL);

    // Exception mode raises the effective level to a floor.
    assign cur_level = (excm && (EXCM_LV > intlevel)) ? EXCM_LV : intlevel;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
    parameter int HAS_DEPC   = 1,
    parameter int HAS_MMU    = 1,
    parameter int EXCM_LEVEL = 3,
    parameter int CAUSE_W    = 6,
    parameter int LVL_W      = 4,
    parameter int SRN_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [31:0]        exc_pc,
    input  logic               exc_vaddr_vld,
    input  logic [31:0]        exc_vaddr,
    input  logic [31:0]        op_pc,
    input  logic               op_rfe,
    input  logic               op_rfde,
    input  logic               op_rsil,
    input  logic [LVL_W-1:0]   rsil_lvl,
    input  logic               sr_rd,
    input  logic               sr_wr,
    input  logic [SRN_W-1:0]   sr_num,
    input  logic [31:0]        sr_wdata,
    output logic [31:0]        fetch_pc,
    output logic               redirect_vld,
    output logic [31:0]        ps,
    output logic [31:0]        epc1,
    output logic [31:0]        depc,
    output logic [31:0]        exccause,
    output logic [31:0]        excvaddr,
    output logic [31:0]        rsil_old,
    output logic [LVL_W-1:0]   cur_level,
    output logic [31:0]        sr_rdata
);
    import exc_pkg::*;

    localparam int CAUSE_PAD = XLEN - CAUSE_W;

    ctl_state_t s_d, s_q;

    logic        priv_fault;
    logic        is_double;
    logic [31:0] handler_vec;

    exc_priv_check #(
        .HAS_MMU (HAS_MMU),
        .SRN_W   (SRN_W)
    ) u_priv (
        .ring_bits (s_q.ps[PS_RING_LSB+1:PS_RING_LSB]),
        .op_rfe    (op_rfe),
        .op_rfde   (op_rfde),
        .op_rsil   (op_rsil),
        .sr_rd     (sr_rd),
        .sr_wr     (sr_wr),
        .sr_num    (sr_num),
        .fault     (priv_fault)
    );

    exc_vector_sel u_vec (
        .excm   (s_q.ps[PS_EXCM_BIT]),
        .um     (s_q.ps[PS_UM_BIT]),
        .dbl    (is_double),
        .vector (handler_vec)
    );

    exc_level_calc #(
        .LVL_W      (LVL_W),
        .EXCM_LEVEL (EXCM_LEVEL)
    ) u_lvl (
        .intlevel  (s_q.ps[LVL_W-1:0]),
        .excm      (s_q.ps[PS_EXCM_BIT]),
        .cur_level (cur_level)
    );

    // Next-state computation: one winner per cycle.
    always_comb begin
        logic               take;
        logic [31:0]        t_pc;
        logic [CAUSE_W-1:0] t_cause;
        logic               t_vwe;

        s_d          = s_q;
        s_d.redirect = 1'b0;
        take         = 1'b0;
        t_pc         = exc_pc;
        t_cause      = exc_cause;
        t_vwe        = 1'b0;

        if (exc_req) begin
            take    = 1'b1;
            t_vwe   = exc_vaddr_vld;
        end else if (priv_fault) begin
            take    = 1'b1;
            t_pc    = op_pc;
            t_cause = CAUSE_W'(CAUSE_PRIVILEGED);
        end else if (op_rfe) begin
            s_d.ps[PS_EXCM_BIT] = 1'b0;
            s_d.fetch_pc        = s_q.epc1;
            s_d.redirect        = 1'b1;
        end else if (op_rfde) begin
            s_d.fetch_pc = (HAS_DEPC != 0) ? s_q.depc : s_q.epc1;
            s_d.redirect = 1'b1;
        end else if (op_rsil) begin
            s_d.old_ps             = s_q.ps;
            s_d.ps[LVL_W-1:0]      = rsil_lvl;
        end else if (sr_wr) begin
            case (sr_num)
                SRN_W'(SR_EPC1):  s_d.epc1  = sr_wdata;
                SRN_W'(SR_DEPC):  if (HAS_DEPC != 0) s_d.depc = sr_wdata;
                SRN_W'(SR_PS):    s_d.ps    = sr_wdata;
                SRN_W'(SR_CAUSE): s_d.cause = sr_wdata;
                SRN_W'(SR_VADDR): s_d.vaddr = sr_wdata;
                default: ;
            endcase
        end

        if (take) begin
            if (t_vwe) s_d.vaddr = exc_vaddr;
            if (is_double && (HAS_DEPC != 0)) s_d.depc = t_pc;
            else if (!is_double || (HAS_DEPC == 0)) s_d.epc1 = t_pc;
            s_d.cause            = {{CAUSE_PAD{1'b0}}, t_cause};
            s_d.ps[PS_EXCM_BIT]  = 1'b1;
            s_d.fetch_pc         = handler_vec;
            s_d.redirect         = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.fetch_pc <= VEC_RESET;
            s_q.ps       <= PS_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (sr_num)
            SRN_W'(SR_EPC1):  sr_rdata = s_q.epc1;
            SRN_W'(SR_DEPC):  sr_rdata = s_q.depc;
            SRN_W'(SR_PS):    sr_rdata = s_q.ps;
            SRN_W'(SR_CAUSE): sr_rdata = s_q.cause;
            SRN_W'(SR_VADDR): sr_rdata = s_q.vaddr;
            default:          sr_rdata = '0;
        endcase
    end

    assign fetch_pc     = s_q.fetch_pc;
    assign redirect_vld = s_q.redirect;
    assign ps           = s_q.ps;
    assign epc1         = s_q.epc1;
    assign depc         = s_q.depc;
    assign exccause     = s_q.cause;
    assign excvaddr     = s_q.vaddr;
    assign rsil_old     = s_q.old_ps;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
    parameter int HAS_MMU = 1,
    parameter int LVL_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_req,
    input logic             op_rfe,
    input logic             op_rfde,
    input logic             op_rsil,
    input logic [LVL_W-1:0] rsil_lvl,
    input logic             sr_rd,
    input logic             sr_wr,
    input logic             redirect_vld,
    input logic [7:0]       ps_lo,
    input logic [31:0]      exccause,
    input logic [LVL_W-1:0] cur_level
);
    logic ring0;
    assign ring0 = (HAS_MMU == 0) || (ps_lo[7:6] == 2'b00);

    a_r4_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> ps_lo[4]);

    a_r5_redirect_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> redirect_vld);

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_req || op_rfe || op_rfde || op_rsil || sr_rd || sr_wr) |=> !redirect_vld);

    a_r9_priv_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req && !ring0 && op_rfe) |=> (exccause == 32'd8));

    a_r7_rfde_keeps_ps: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req && ring0 && !op_rfe && op_rfde) |=> $stable(ps_lo));

    a_r8_rsil_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req && ring0 && !op_rfe && !op_rfde && op_rsil)
        |=> (ps_lo[LVL_W-1:0] == $past(rsil_lvl)));

    a_r11_level_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cur_level >= ps_lo[LVL_W-1:0]);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
    .HAS_MMU (HAS_MMU),
    .LVL_W   (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_req      (exc_req),
    .op_rfe       (op_rfe),
    .op_rfde      (op_rfde),
    .op_rsil      (op_rsil),
    .rsil_lvl     (rsil_lvl),
    .sr_rd        (sr_rd),
    .sr_wr        (sr_wr),
    .redirect_vld (redirect_vld),
    .ps_lo        (ps[7:0]),
    .exccause     (exccause),
    .cur_level    (cur_level)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] V_RST = 32'h5FFF_8000;
    localparam logic [31:0] V_KRN = 32'h5FFF_861C;
    localparam logic [31:0] V_USR = 32'h5FFF_863C;
    localparam logic [31:0] V_DBL = 32'h5FFF_865C;
    localparam int EXCM_LV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_req = 0, exc_vaddr_vld = 0, op_rfe = 0, op_rfde = 0, op_rsil = 0;
    logic sr_rd = 0, sr_wr = 0;
    logic [5:0] exc_cause = '0;
    logic [31:0] exc_pc = '0, exc_vaddr = '0, op_pc = '0, sr_wdata = '0;
    logic [3:0] rsil_lvl = '0;
    logic [7:0] sr_num = '0;
    logic [31:0] fetch_pc, ps, epc1, depc, exccause, excvaddr, rsil_old, sr_rdata;
    logic redirect_vld;
    logic [3:0] cur_level;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        string       tag;
        logic [31:0] pc, ps, epc1, depc, cause, vaddr, oldps;
        logic        redir;
        logic [3:0]  lvl;
    } exp_t;
    exp_t sb[$];

    logic [31:0] m_pc, m_ps, m_epc1, m_depc, m_cause, m_vaddr, m_old;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_pc(exc_pc), .exc_vaddr_vld(exc_vaddr_vld), .exc_vaddr(exc_vaddr),
        .op_pc(op_pc), .op_rfe(op_rfe), .op_rfde(op_rfde), .op_rsil(op_rsil),
        .rsil_lvl(rsil_lvl), .sr_rd(sr_rd), .sr_wr(sr_wr), .sr_num(sr_num),
        .sr_wdata(sr_wdata), .fetch_pc(fetch_pc), .redirect_vld(redirect_vld),
        .ps(ps), .epc1(epc1), .depc(depc), .exccause(exccause),
        .excvaddr(excvaddr), .rsil_old(rsil_old), .cur_level(cur_level),
        .sr_rdata(sr_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] lvl_of(input logic [31:0] p);
        return (p[4] && (4'(EXCM_LV) > p[3:0])) ? 4'(EXCM_LV) : p[3:0];
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop and compare expected items as they fall due.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            chk(e.tag, "fetch_pc", fetch_pc, e.pc);
            chk(e.tag, "redirect", 32'(redirect_vld), 32'(e.redir));
            chk(e.tag, "ps", ps, e.ps);
            chk(e.tag, "epc1", epc1, e.epc1);
            chk(e.tag, "depc", depc, e.depc);
            chk(e.tag, "exccause", exccause, e.cause);
            chk(e.tag, "excvaddr", excvaddr, e.vaddr);
            chk(e.tag, "rsil_old", rsil_old, e.oldps);
            chk(e.tag, "cur_level", 32'(cur_level), 32'(e.lvl));
        end
    end

    task automatic m_take(input logic [31:0] pc, input logic [5:0] c,
                          input logic vv, input logic [31:0] va);
        logic dbl;
        dbl = m_ps[4];
        if (vv) m_vaddr = va;
        if (dbl) m_depc = pc; else m_epc1 = pc;
        m_cause = {26'd0, c};
        m_pc = dbl ? V_DBL : (m_ps[5] ? V_USR : V_KRN);
        m_ps[4] = 1'b1;
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input string tag, input logic e, input logic [5:0] c,
                        input logic [31:0] epc, input logic vv, input logic [31:0] va,
                        input logic rfe, input logic rfde, input logic rs,
                        input logic [3:0] lv, input logic rd, input logic wr,
                        input logic [7:0] num, input logic [31:0] wd,
                        input logic [31:0] opc);
        exp_t x;
        logic redir, privop;
        @(negedge clk);
        exc_req = e; exc_cause = c; exc_pc = epc; exc_vaddr_vld = vv; exc_vaddr = va;
        op_rfe = rfe; op_rfde = rfde; op_rsil = rs; rsil_lvl = lv;
        sr_rd = rd; sr_wr = wr; sr_num = num; sr_wdata = wd; op_pc = opc;
        privop = rfe | rfde | rs | ((rd | wr) && (num >= 8'd64));
        redir = 1'b0;
        if (e) begin
            m_take(epc, c, vv, va); redir = 1'b1;
        end else if (privop && m_ps[7:6] != 2'b00) begin
            m_take(opc, 6'd8, 1'b0, 32'd0); redir = 1'b1;
        end else if (rfe) begin
            m_ps[4] = 1'b0; m_pc = m_epc1; redir = 1'b1;
        end else if (rfde) begin
            m_pc = m_depc; redir = 1'b1;
        end else if (rs) begin
            m_old = m_ps; m_ps[3:0] = lv;
        end else if (wr) begin
            case (num)
                8'd177: m_epc1 = wd;
                8'd192: m_depc = wd;
                8'd230: m_ps = wd;
                8'd232: m_cause = wd;
                8'd238: m_vaddr = wd;
                default: ;
            endcase
        end
        x.due = cyc + 1; x.tag = tag; x.pc = m_pc; x.ps = m_ps; x.epc1 = m_epc1;
        x.depc = m_depc; x.cause = m_cause; x.vaddr = m_vaddr; x.oldps = m_old;
        x.redir = redir; x.lvl = lvl_of(m_ps);
        sb.push_back(x);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 6'd0, 32'd0, 0, 32'd0, 0, 0, 0, 4'd0, 0, 0, 8'd0, 32'd0, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_pc = V_RST; m_ps = 32'h1F; m_epc1 = 0; m_depc = 0;
        m_cause = 0; m_vaddr = 0; m_old = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state; R11 level at reset
        checks++;
        chk("R1", "fetch_pc", fetch_pc, V_RST);
        chk("R1", "ps", ps, 32'h1F);
        chk("R1", "epc1", epc1, 32'd0);
        chk("R1", "depc", depc, 32'd0);
        chk("R1", "exccause", exccause, 32'd0);
        chk("R1", "redirect", 32'(redirect_vld), 32'd0);
        chk("R11", "cur_level", 32'(cur_level), 32'hF);

        // R8 set level to 2; R11 floor lifts it to 3 while exception mode is on
        step("R8", 0, 6'd0, 0, 0, 0, 0, 0, 1, 4'd2, 0, 0, 8'd0, 0, 0);
        // R6 return clears exception mode, jumps to epc1
        step("R6", 0, 6'd0, 0, 0, 0, 1, 0, 0, 4'd0, 0, 0, 8'd0, 0, 0);
        // R2 kernel entry
        step("R2", 1, 6'd1, 32'h100, 0, 0, 0, 0, 0, 4'd0, 0, 0, 8'd0, 0, 0);
        // R3 double entry with an address-related cause; R4 vaddr written
        step("R3", 1, 6'd28, 32'h200, 1, 32'hDEAD_0004, 0, 0, 0, 4'd0, 0, 0, 8'd0, 0, 0);
        // R7 return from double
        step("R7", 0, 6'd0, 0, 0, 0, 0, 1, 0, 4'd0, 0, 0, 8'd0, 0, 0);
        step("R6", 0, 6'd0, 0, 0, 0, 1, 0, 0, 4'd0, 0, 0, 8'd0, 0, 0);
        // R12 exception and return together: exception wins
        step("R12", 1, 6'd0, 32'h240, 0, 0, 1, 0, 0, 4'd0, 0, 0, 8'd0, 0, 0);
        // R13 write PS: user mode, ring 0
        step("R13", 0, 6'd0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 1, 8'd230, 32'h20, 0);
        // R13 read back epc1 through the read port
        step("R13", 0, 6'd0, 0, 0, 0, 0, 0, 0, 4'd0, 1, 0, 8'd177, 0, 0);
        #1;
        checks++;
        chk("R13", "sr_rdata", sr_rdata, 32'h240);
        // R2 user entry; R4 vaddr holds when not valid
        step("R2", 1, 6'd1, 32'h300, 0, 32'h55, 0, 0, 0, 4'd0, 0, 0, 8'd0, 0, 0);
        // R13 write PS to ring 1
        step("R13", 0, 6'd0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 1, 8'd230, 32'h40, 0);
        // R9 return in ring 1 traps with cause 8
        step("R9", 0, 6'd0, 0, 0, 0, 1, 0, 0, 4'd0, 0, 0, 8'd0, 0, 32'h400);
        // R9 privileged write in ring 1 traps (double entry)
        step("R9", 0, 6'd0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 1, 8'd230, 32'h0, 32'h500);
        // R10 low-numbered write in ring 1: no trap, no change
        step("R10", 0, 6'd0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 1, 8'd3, 32'h77, 32'h580);
        // R9 set level in ring 1 traps
        step("R9", 0, 6'd0, 0, 0, 0, 0, 0, 1, 4'd1, 0, 0, 8'd0, 0, 32'h600);
        // R5 quiet cycle: no redirect
        idle("R5");
        idle("R5");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule